// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block is the configuration front end of a legacy I/O-mapped peripheral controller. It answers on a pair of byte-wide I/O addresses: the lower one holds a register number (the index) and the one above it moves data to or from the register that the index names. All access to the registers is closed until software writes a two-byte enter key to the index address. A separate exit key closes access again.

While the port is open, software can reach a set of shared global registers and a bank of per-device registers. The bank in view is chosen by a device-select register. Two global registers return a fixed identity code and revision. One global register reports a board strap, and that strap also decides which of two address pairs the block answers on. Bit 0 of each device's activation register is brought out as that device's enable. The selected device number is also driven out so that neighbouring logic can see it.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the index and all stored registers are 0x00, the device select output is 0, every device enable is 0 and `io_rdata` is 0x00.
- R2: The port opens, and `cfg_open` rises, in the cycle after the second of two back-to-back index writes of 0x87.
- R3: While locked, an index write of any value other than 0x87 discards a pending first key, so the sequence 0x87, other, 0x87 leaves the port locked.
- R4: While open, an index write of 0xAA locks the port in the next cycle and leaves the stored index unchanged; any other value written to the index becomes the new index.
- R5: While locked, a data read returns 0xFF and an index read returns 0xFF. Data writes are ignored and change no register.
- R6: With `strap_alt` low the index is at `BASE_A` and the data port at `BASE_A`+1. With it high they are at `BASE_B` and `BASE_B`+1. Accesses at any other address have no effect.
- R7: Register 0x07 is read/write and holds the selected device number, which is driven on `ldev_sel`.
- R8: Register 0x20 reads `DEV_ID` and register 0x21 reads `DEV_REV`; writes to both are ignored.
- R9: Register 0x26 reads the strap in bit 6 (0 for `BASE_A`, 1 for `BASE_B`); its other seven bits are read/write storage.
- R10: Register 0x30 and registers 0xF0 to 0xFF are kept separately for each device number below `NDEV`, in the bank chosen by register 0x07. Bit 0 of a device's 0x30 drives `dev_en[device]`.
- R11: Registers below 0x30 other than 0x07, 0x20, 0x21 and 0x26 are read/write storage that is shared by every bank.
- R12: A read returns its value on `io_rdata` in the cycle after the read strobe, and `io_rdata` holds that value until the next read that hits the port. An open index read returns the current index.
- R13: Banked registers read 0xFF and ignore writes when the selected device is `NDEV` or above. Indices 0x31 to 0xEF read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| strap_alt | input | 1 | Address pair select strap |
| cfg_open | output | 1 | Port is unlocked |
| ldev_sel | output | 8 | Selected device number |
| dev_en | output | NDEV | Per-device enable, bit 0 of each 0x30 |

## Verification
Every output of this block is registered. A key or index write therefore shows on `cfg_open`, and a data write shows on `ldev_sel` and `dev_en`, one clock after its strobe. Read data lands on `io_rdata` in that same next cycle. The bench drives its strobes on the falling edge and updates its reference model on the rising edge that captures them. It compares all outputs on the following falling edge, so each result is checked in exactly the cycle it is due. Directed reads wait one full cycle after the strobe before checking a fixed expected value.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam logic [7:0] KEY_ENTER = 8'h87;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;
    localparam logic [7:0] IX_LDEV   = 8'h07;
    localparam logic [7:0] IX_ID     = 8'h20;
    localparam logic [7:0] IX_REV    = 8'h21;
    localparam logic [7:0] IX_STRAP  = 8'h26;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] IX_BANKLO = 8'hF0;
    localparam int         STRAP_BIT = 6;
    localparam int         GLOB_N    = 48;
    localparam int         BANK_N    = 17;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] cur_idx
);
    typedef struct packed {
        key_state_e st;
        logic [7:0] idx;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (idx_wr) begin
            unique case (k_q.st)
                KS_LOCKED: if (wdata == KEY_ENTER) k_d.st = KS_HALF;
                KS_HALF:   k_d.st = (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
                KS_OPEN: begin
                    if (wdata == KEY_EXIT) k_d.st = KS_LOCKED;
                    else                   k_d.idx = wdata;
                end
                default:   k_d.st = KS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '{st: KS_LOCKED, idx: 8'h00};
        else        k_q <= k_d;
    end

    assign unlocked = (k_q.st == KS_OPEN);
    assign cur_idx  = k_q.idx;

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_ENTER));
    // R3
    key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && k_q.st == KS_HALF && wdata != KEY_ENTER) |=> k_q.st == KS_LOCKED);
    // R4
    exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> ($past(idx_wr && wdata == KEY_EXIT) && $stable(cur_idx)));
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
    import sio_cfg_pkg::*;
#(
    parameter int         NDEV    = 10,
    parameter logic [7:0] DEV_ID  = 8'hC1,
    parameter logic [7:0] DEV_REV = 8'h0A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      idx,
    input  logic [7:0]      wdata,
    input  logic            strap,
    output logic [7:0]      rd_data,
    output logic [7:0]      ldev,
    output logic [NDEV-1:0] dev_en
);
    localparam int SLOT_W = $clog2(BANK_N);

    typedef struct packed {
        logic [GLOB_N-1:0][7:0]             glob;
        logic [NDEV-1:0][BANK_N-1:0][7:0]   bank;
    } rf_t;

    rf_t r_d, r_q;

    logic              is_glob, is_bank, ldev_ok;
    logic [SLOT_W-1:0] slot;
    int unsigned       dsel;

    assign ldev    = r_q.glob[IX_LDEV[5:0]];
    assign is_glob = (idx < IX_ACT);
    assign is_bank = (idx == IX_ACT) || (idx >= IX_BANKLO);
    assign slot    = (idx == IX_ACT) ? '0 : SLOT_W'(idx[3:0]) + SLOT_W'(1);
    assign ldev_ok = (int'(ldev) < NDEV);
    assign dsel    = ldev_ok ? int'(ldev) : 0;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (is_glob) begin
                if (idx == IX_STRAP)
                    r_d.glob[idx[5:0]] = wdata & ~(8'h01 << STRAP_BIT);
                else if (idx != IX_ID && idx != IX_REV)
                    r_d.glob[idx[5:0]] = wdata;
            end else if (is_bank && ldev_ok) begin
                r_d.bank[dsel][slot] = wdata;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (idx == IX_ID)          rd_data = DEV_ID;
        else if (idx == IX_REV)    rd_data = DEV_REV;
        else if (idx == IX_STRAP) begin
            rd_data = r_q.glob[idx[5:0]];
            rd_data[STRAP_BIT] = strap;
        end
        else if (is_glob)          rd_data = r_q.glob[idx[5:0]];
        else if (is_bank)          rd_data = ldev_ok ? r_q.bank[dsel][slot] : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_en
        assign dev_en[g] = r_q.bank[g][0][0];
    end

    // R7
    ldev_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ldev) |-> $past(wr_en && idx == IX_LDEV));
    // R10
    dev_en_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_en) |-> $past(wr_en && idx == IX_ACT && ldev_ok));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_A  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_B  = 16'h004E,
    parameter int                NDEV    = 10,
    parameter logic [7:0]        DEV_ID  = 8'hC1,
    parameter logic [7:0]        DEV_REV = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              strap_alt,
    output logic              cfg_open,
    output logic [7:0]        ldev_sel,
    output logic [NDEV-1:0]   dev_en
);
    typedef struct packed {
        logic [7:0] rdata;
    } port_t;

    port_t p_d, p_q;

    logic [ADDR_W-1:0] base;
    logic              hit_idx, hit_dat;
    logic [7:0]        cur_idx, rf_rd;

    assign base    = strap_alt ? BASE_B : BASE_A;
    assign hit_idx = (io_addr == base);
    assign hit_dat = (io_addr == base + ADDR_W'(1));

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .unlocked (cfg_open),
        .cur_idx  (cur_idx)
    );

    sio_reg_file #(
        .NDEV    (NDEV),
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr && hit_dat && cfg_open),
        .idx     (cur_idx),
        .wdata   (io_wdata),
        .strap   (strap_alt),
        .rd_data (rf_rd),
        .ldev    (ldev_sel),
        .dev_en  (dev_en)
    );

    always_comb begin
        p_d = p_q;
        if (io_rd && hit_idx)      p_d.rdata = cfg_open ? cur_idx : 8'hFF;
        else if (io_rd && hit_dat) p_d.rdata = cfg_open ? rf_rd : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign io_rdata = p_q.rdata;

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (hit_idx || hit_dat) && !cfg_open) |=> io_rdata == 8'hFF);
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
    // R8
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_dat && cfg_open && cur_idx == IX_ID) |=> io_rdata == DEV_ID);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
    localparam int         NDEV = 10;
    localparam logic [7:0] DID  = 8'hC1;
    localparam logic [7:0] DREV = 8'h0A;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] io_addr = 0;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_wdata = 0;
    logic [7:0]  io_rdata;
    logic        strap_alt = 0;
    logic        cfg_open;
    logic [7:0]  ldev_sel;
    logic [NDEV-1:0] dev_en;

    always #2.5 clk = ~clk;

    sio_cfg_port #(.NDEV(NDEV), .DEV_ID(DID), .DEV_REV(DREV)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .strap_alt(strap_alt),
        .cfg_open(cfg_open), .ldev_sel(ldev_sel), .dev_en(dev_en));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference
    int m_key, m_idx, m_rd;
    int mg[48];
    int mb[NDEV][17];

    function automatic int m_read(int ix);
        int ld = mg[7];
        if (ix == 8'h20) return DID;
        if (ix == 8'h21) return DREV;
        if (ix == 8'h26) return (mg[ix] & 8'hBF) | (strap_alt ? 8'h40 : 0);
        if (ix < 8'h30) return mg[ix];
        if (ix == 8'h30) return (ld < NDEV) ? mb[ld][0] : 8'hFF;
        if (ix >= 8'hF0) return (ld < NDEV) ? mb[ld][ix - 8'hF0 + 1] : 8'hFF;
        return 0;
    endfunction

    function automatic void m_write(int ix, int v);
        int ld = mg[7];
        if (ix == 8'h20 || ix == 8'h21) return;
        if (ix == 8'h26) mg[ix] = v & 8'hBF;
        else if (ix < 8'h30) mg[ix] = v;
        else if (ix == 8'h30 && ld < NDEV) mb[ld][0] = v;
        else if (ix >= 8'hF0 && ld < NDEV) mb[ld][ix - 8'hF0 + 1] = v;
    endfunction

    always @(posedge clk) begin
        int base;
        base = strap_alt ? 8'h4E : 8'h2E;
        if (!rst_n) begin
            m_key = 0; m_idx = 0; m_rd = 0;
            foreach (mg[i]) mg[i] = 0;
            foreach (mb[i, j]) mb[i][j] = 0;
        end else if (io_wr && io_addr == base) begin
            if (m_key == 2) begin
                if (io_wdata == 8'hAA) m_key = 0; else m_idx = io_wdata;
            end else if (io_wdata == 8'h87) m_key = m_key + 1;
            else m_key = 0;
        end else if (io_wr && io_addr == base + 1) begin
            if (m_key == 2) m_write(m_idx, io_wdata);
        end else if (io_rd && io_addr == base) begin
            m_rd = (m_key == 2) ? m_idx : 8'hFF;
        end else if (io_rd && io_addr == base + 1) begin
            m_rd = (m_key == 2) ? m_read(m_idx) : 8'hFF;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [NDEV-1:0] exp_en;
            for (int d = 0; d < NDEV; d++) exp_en[d] = mb[d][0][0];
            n_cmp++;
            if (io_rdata !== 8'(m_rd) || cfg_open !== (m_key == 2) ||
                ldev_sel !== 8'(mg[7]) || dev_en !== exp_en) begin
                n_bad++;
                $display("FAIL %s: rdata=%h open=%b ldev=%h en=%b exp %h %b %h %b",
                    phase, io_rdata, cfg_open, ldev_sel, dev_en,
                    8'(m_rd), (m_key == 2), 8'(mg[7]), exp_en);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk); io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk); io_addr = 16'(a); io_rd = 1;
        @(negedge clk); io_rd = 0;
        chk(tag, io_rdata, exp);
    endtask

    task automatic reg_wr(int ix, int v);
        wr(8'h2E, ix); wr(8'h2F, v);
    endtask

    task automatic reg_rd(int ix, int exp, string tag);
        wr(8'h2E, ix); rd(8'h2F, exp, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 open", cfg_open, 0);
        chk("R1 ldev", ldev_sel, 0);
        chk("R1 en", dev_en, 0);
        chk("R1 rdata", io_rdata, 0);

        phase = "R5";
        rd(8'h2F, 8'hFF, "R5 locked data read");
        rd(8'h2E, 8'hFF, "R5 locked index read");
        wr(8'h2F, 8'h5A);

        phase = "R6";
        wr(8'h4E, 8'h87); wr(8'h4E, 8'h87);
        chk("R6 wrong pair stays locked", cfg_open, 0);

        phase = "R3";
        wr(8'h2E, 8'h87); wr(8'h2E, 8'h12); wr(8'h2E, 8'h87);
        chk("R3 broken key", cfg_open, 0);
        wr(8'h2E, 8'h00);

        phase = "R2";
        wr(8'h2E, 8'h87);
        chk("R2 half key", cfg_open, 0);
        wr(8'h2E, 8'h87);
        chk("R2 open", cfg_open, 1);

        phase = "R5";
        reg_rd(8'h00, 8'h00, "R5 locked write ignored");

        phase = "R7";
        reg_wr(8'h07, 8);
        chk("R7 ldev", ldev_sel, 8);
        reg_rd(8'h07, 8, "R7 readback");

        phase = "R10";
        reg_wr(8'h30, 8'h01);
        chk("R10 enable", dev_en, 10'h100);
        reg_wr(8'hF6, 8'h3C);
        reg_wr(8'h07, 3);
        reg_rd(8'hF6, 8'h00, "R10 other bank empty");
        reg_wr(8'hF6, 8'h11);
        reg_wr(8'hFF, 8'h77);
        reg_wr(8'h07, 8);
        reg_rd(8'hF6, 8'h3C, "R10 bank kept");
        reg_rd(8'hFF, 8'h00, "R10 top reg banked");

        phase = "R11";
        reg_wr(8'h2B, 8'h5A);
        reg_wr(8'h07, 3);
        reg_rd(8'h2B, 8'h5A, "R11 shared");

        phase = "R8";
        reg_rd(8'h20, DID, "R8 id");
        reg_wr(8'h20, 8'h00);
        reg_rd(8'h20, DID, "R8 id write ignored");
        reg_wr(8'h21, 8'h00);
        reg_rd(8'h21, DREV, "R8 rev");

        phase = "R9";
        reg_wr(8'h26, 8'hFF);
        reg_rd(8'h26, 8'hBF, "R9 strap low");

        phase = "R6";
        strap_alt = 1;
        rd(8'h4F, 8'hFF, "R9 strap high via alt pair");
        rd(8'h2F, 8'hFF, "R6 old pair ignored");
        wr(8'h4E, 8'h2B); wr(8'h2F, 8'h00);
        rd(8'h4F, 8'h5A, "R6 alt pair");
        strap_alt = 0;

        phase = "R13";
        reg_rd(8'h50, 8'h00, "R13 hole");
        reg_wr(8'h50, 8'h44);
        reg_rd(8'h50, 8'h00, "R13 hole write");
        reg_wr(8'h07, 12);
        reg_rd(8'h30, 8'hFF, "R13 no such device");
        reg_wr(8'hF6, 8'h99);

        phase = "R12";
        wr(8'h2E, 8'hF6);
        rd(8'h2E, 8'hF6, "R12 index read");
        repeat (3) @(negedge clk);
        chk("R12 hold", io_rdata, 8'hF6);

        phase = "R4";
        wr(8'h2E, 8'hAA);
        chk("R4 locked", cfg_open, 0);
        rd(8'h2F, 8'hFF, "R4 data closed");
        wr(8'h2E, 8'h87); wr(8'h2E, 8'h87);
        rd(8'h2E, 8'hF6, "R4 index kept");
        reg_wr(8'h07, 8);
        reg_rd(8'hF6, 8'h3C, "R13 bank untouched");

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule